// File: doc/BRIEF.md
# Configurable Interrupt Source Conditioner

This block sits between a set of already-synchronised wired interrupt lines and a priority arbitration stage. Each source is identified by a number from 1 to `NSRC`. Each source has a sense mode, chosen at run time, that decides how its line is turned into a pending bit: inactive, rising edge, falling edge, level high or level low. The block also keeps a per-source enable bit. The pending and enable vectors go straight to the arbiter. A claim path can clear one source's pending bit by naming its identity.

Software reaches the block over a simple word-wide register bus. A write and a combinational read are available in every cycle. Sense modes are written per source. There are two ways to change enables: name a single source in a set-enable or a clear-enable register, or write a 32-bit mask to a bank clear register. Bank registers and pending banks can also be read back. Bit j of bank b stands for source 32·b+j.

Top module: `irq_src_cond`

## Requirements
- R1: The sense mode of source k sits in bits [2:0] of the word at word address k−1. The codes are 0 inactive, 1 rising, 2 falling, 3 level high and 4 level low. A written code of 5, 6 or 7 is stored as 0, and reads return the stored code.
- R2: An inactive source is never pending, whatever its input does. Writing mode 0 to a pending source clears that source's pending bit.
- R3: In rising mode, a 0→1 change of the input sets pending at the next clock edge. Pending then stays set until it is claimed or the mode is rewritten.
- R4: In falling mode, a 1→0 change of the input sets pending at the next clock edge. Pending then stays set in the same way as in R3.
- R5: In level-high mode, pending equals the input as registered at the previous edge. In level-low mode, pending equals the inverted input.
- R6: A claim strobe (`claim_valid` with `claim_id` = k) clears the pending bit of source k. A level source whose input is still asserted is pending again one cycle later. In an edge mode, a fresh selected edge in the same cycle as the claim keeps the source pending.
- R7: Writing identity k to word 128 enables source k. Writing k to word 129 disables source k.
- R8: A write to word 136+b disables every source 32·b+j for which bit j of the data is 1. A read of word 136+b returns the enable bits of that bank, and a read of word 144+b returns its pending bits. Bits for identity 0 and for identities above `NSRC` read as 0.
- R9: Set-enable, clear-enable and claim strobes that name identity 0, or an identity above `NSRC`, change nothing.
- R10: A mode write clears the source's pending bit and resets its edge history. An input level that is already present, or that changes in the same cycle as the write, does not leave the source pending.
- R11: After reset, every source is inactive, not pending and disabled, and all readable words return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | NSRC | Synchronised interrupt lines; bit k−1 is source k |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| claim_valid | input | 1 | Claim-clear strobe |
| claim_id | input | ID_W | Identity whose pending bit the claim clears |
| pend_o | output | NSRC | Pending vector; bit k−1 is source k |
| en_o | output | NSRC | Enable vector; bit k−1 is source k |

## Verification
The assertions assume that the interrupt lines are already synchronised to `clk` and change only between edges. They also assume that the bus names at most one register per cycle, so that a set and a clear can never reach the same source from two different addresses. The bench drives every input shortly after a rising edge and issues a single bus operation per cycle. Its random phase mixes in identities 0 and just above `NSRC`, mode codes above 4 and arbitrary bank masks, so the ignore rules are exercised without breaking these assumptions.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;

    typedef enum logic [2:0] {
        MODE_OFF  = 3'd0,
        MODE_RISE = 3'd1,
        MODE_FALL = 3'd2,
        MODE_HIGH = 3'd3,
        MODE_LOW  = 3'd4
    } sense_e;

    // Word addresses of the shared registers (mode words occupy 0..NSRC-1)
    localparam int A_SETNUM   = 128;
    localparam int A_CLRNUM   = 129;
    localparam int A_ENBANK   = 136;
    localparam int A_PENDBANK = 144;

    function automatic sense_e to_sense(logic [2:0] code);
        if (code > 3'd4) return MODE_OFF;
        return sense_e'(code);
    endfunction

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import irq_cond_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq_i,
    input  logic       cfg_we,
    input  logic [2:0] cfg_mode,
    input  logic       en_set,
    input  logic       en_clr,
    input  logic       pend_clr,
    output sense_e     mode_o,
    output logic       pend_o,
    output logic       en_o
);

    typedef struct packed {
        sense_e mode;
        logic   prev;
        logic   pend;
        logic   en;
    } cell_t;

    cell_t s_d, s_q;
    logic  rise, fall;

    always_comb begin
        s_d      = s_q;
        s_d.prev = irq_i;
        rise     = irq_i & ~s_q.prev;
        fall     = ~irq_i & s_q.prev;
        unique case (s_q.mode)
            MODE_RISE: s_d.pend = (s_q.pend & ~pend_clr) | rise;
            MODE_FALL: s_d.pend = (s_q.pend & ~pend_clr) | fall;
            MODE_HIGH: s_d.pend = irq_i & ~pend_clr;
            MODE_LOW:  s_d.pend = ~irq_i & ~pend_clr;
            default:   s_d.pend = 1'b0;
        endcase
        if (cfg_we) begin
            s_d.mode = to_sense(cfg_mode);
            s_d.pend = 1'b0;
        end
        if (en_set) s_d.en = 1'b1;
        if (en_clr) s_d.en = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{mode: MODE_OFF, prev: 1'b0, pend: 1'b0, en: 1'b0};
        else        s_q <= s_d;
    end

    assign mode_o = s_q.mode;
    assign pend_o = s_q.pend;
    assign en_o   = s_q.en;

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_OFF) |-> !pend_o); // R2
    AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_RISE && !cfg_we && irq_i && !s_q.prev) |=> pend_o); // R3
    AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o == MODE_RISE || mode_o == MODE_FALL) && pend_o && !pend_clr && !cfg_we) |=> pend_o); // R3
    AST_FALL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_FALL && !cfg_we && !irq_i && s_q.prev) |=> pend_o); // R4
    AST_LEVEL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_HIGH && !cfg_we && !pend_clr) |=> (pend_o == $past(irq_i))); // R5
    AST_CLAIM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_RISE && pend_clr && !cfg_we && !(irq_i && !s_q.prev)) |=> !pend_o); // R6
    AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !pend_o); // R10
    AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (en_set && !en_clr) |=> en_o); // R7
    AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr |=> !en_o); // R8

endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_cond_pkg::*;
#(
    parameter int NSRC   = 40,
    parameter int ADDR_W = 8,
    parameter int ID_W   = 8
) (
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              claim_valid,
    input  logic [ID_W-1:0]   claim_id,
    output logic [NSRC-1:0]   cfg_we,
    output logic [NSRC-1:0]   en_set,
    output logic [NSRC-1:0]   en_clr,
    output logic [NSRC-1:0]   pend_clr
);

    logic wr_setnum, wr_clrnum;

    assign wr_setnum = bus_we && (bus_addr == ADDR_W'(A_SETNUM));
    assign wr_clrnum = bus_we && (bus_addr == ADDR_W'(A_CLRNUM));

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam int K    = i + 1;
        localparam int BANK = K / 32;
        localparam int BIT  = K % 32;
        assign cfg_we[i]   = bus_we && (bus_addr == ADDR_W'(i));
        assign en_set[i]   = wr_setnum && (bus_wdata == 32'(K));
        assign en_clr[i]   = (wr_clrnum && (bus_wdata == 32'(K)))
                           || (bus_we && (bus_addr == ADDR_W'(A_ENBANK + BANK)) && bus_wdata[BIT]);
        assign pend_clr[i] = claim_valid && (claim_id == ID_W'(K));
    end

endmodule

// File: rtl/irq_src_cond.sv
module irq_src_cond
    import irq_cond_pkg::*;
#(
    parameter int NSRC   = 40,
    parameter int ADDR_W = 8,
    parameter int ID_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_i,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              claim_valid,
    input  logic [ID_W-1:0]   claim_id,
    output logic [NSRC-1:0]   pend_o,
    output logic [NSRC-1:0]   en_o
);

    localparam int NBANK = NSRC / 32 + 1;

    logic [NSRC-1:0] cfg_we, en_set, en_clr, pend_clr;
    sense_e          mode_w [NSRC];
    logic [NBANK*32-1:0] en_pad, pend_pad;

    irq_reg_decode #(.NSRC(NSRC), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_dec (
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .claim_valid (claim_valid),
        .claim_id    (claim_id),
        .cfg_we      (cfg_we),
        .en_set      (en_set),
        .en_clr      (en_clr),
        .pend_clr    (pend_clr)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_cell
        irq_src_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .irq_i    (irq_i[i]),
            .cfg_we   (cfg_we[i]),
            .cfg_mode (bus_wdata[2:0]),
            .en_set   (en_set[i]),
            .en_clr   (en_clr[i]),
            .pend_clr (pend_clr[i]),
            .mode_o   (mode_w[i]),
            .pend_o   (pend_o[i]),
            .en_o     (en_o[i])
        );
    end

    always_comb begin
        en_pad             = '0;
        pend_pad           = '0;
        en_pad[NSRC:1]     = en_o;
        pend_pad[NSRC:1]   = pend_o;
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NSRC; i++)
            if (bus_addr == ADDR_W'(i)) bus_rdata = {29'b0, 3'(mode_w[i])};
        for (int b = 0; b < NBANK; b++) begin
            if (bus_addr == ADDR_W'(A_ENBANK + b))   bus_rdata = en_pad[b*32 +: 32];
            if (bus_addr == ADDR_W'(A_PENDBANK + b)) bus_rdata = pend_pad[b*32 +: 32];
        end
    end

    AST_BAD_SETNUM: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(A_SETNUM) && (bus_wdata == 32'd0 || bus_wdata > 32'(NSRC)))
        |=> $stable(en_o)); // R9
    AST_BAD_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_valid && (claim_id == '0 || 32'(claim_id) > 32'(NSRC))) |-> (pend_clr == '0)); // R9

endmodule

// File: tb/irq_src_cond_test.sv
module irq_src_cond_test;
    localparam int NSRC       = 40;
    localparam int ADDR_W     = 8;
    localparam int ID_W       = 8;
    localparam int CLK_PERIOD = 10;

    logic              clk = 0;
    logic              rst_n = 0;
    logic [NSRC-1:0]   irq = '0;
    logic              bus_we = 0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              claim_valid = 0;
    logic [ID_W-1:0]   claim_id = '0;
    logic [NSRC-1:0]   pend_o, en_o;

    irq_src_cond #(.NSRC(NSRC), .ADDR_W(ADDR_W), .ID_W(ID_W)) uut (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .claim_valid(claim_valid),
        .claim_id(claim_id), .pend_o(pend_o), .en_o(en_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    logic [2:0]    m_mode [NSRC+1];
    logic [NSRC:1] m_pend = '0, m_en = '0, m_prev = '0;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Next state of every source from the requirements, for the inputs now applied
    task automatic model_tick();
        for (int k = 1; k <= NSRC; k++) begin
            logic in, rise, fall, clr, p;
            in   = irq[k-1];
            rise = in & ~m_prev[k];
            fall = ~in & m_prev[k];
            clr  = claim_valid && (32'(claim_id) == k);
            case (m_mode[k])
                3'd1: p = (m_pend[k] & ~clr) | rise;
                3'd2: p = (m_pend[k] & ~clr) | fall;
                3'd3: p = in & ~clr;
                3'd4: p = ~in & ~clr;
                default: p = 1'b0;
            endcase
            if (bus_we && bus_addr == ADDR_W'(k-1)) begin
                m_mode[k] = (bus_wdata[2:0] > 3'd4) ? 3'd0 : bus_wdata[2:0];
                p = 1'b0;
            end
            if (bus_we && bus_addr == 8'd128 && bus_wdata == 32'(k)) m_en[k] = 1'b1;
            if (bus_we && bus_addr == 8'd129 && bus_wdata == 32'(k)) m_en[k] = 1'b0;
            if (bus_we && bus_addr == ADDR_W'(136 + k/32) && bus_wdata[k%32]) m_en[k] = 1'b0;
            m_pend[k] = p;
            m_prev[k] = in;
        end
    endtask

    function automatic logic [31:0] exp_read(int a);
        logic [63:0] e, p;
        e = '0; p = '0;
        e[NSRC:1] = m_en; p[NSRC:1] = m_pend;
        if (a < NSRC) return {29'b0, m_mode[a+1]};
        if (a == 136) return e[31:0];
        if (a == 137) return e[63:32];
        if (a == 144) return p[31:0];
        if (a == 145) return p[63:32];
        return 32'h0;
    endfunction

    task automatic cycle(string tag);
        model_tick();
        @(posedge clk); #1;
        bus_we = 0; claim_valid = 0;
        check({tag, " pend"}, 64'(pend_o), 64'(m_pend[NSRC:1]));
        check({tag, " en"},   64'(en_o),   64'(m_en[NSRC:1]));
    endtask

    task automatic wr(int a, logic [31:0] d);
        bus_we = 1; bus_addr = ADDR_W'(a); bus_wdata = d;
    endtask

    task automatic rd_check(string tag, int a, logic [31:0] exp);
        bus_addr = ADDR_W'(a); #1;
        check(tag, 64'(bus_rdata), 64'(exp));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int k = 0; k <= NSRC; k++) m_mode[k] = 3'd0;
        #(CLK_PERIOD*3); @(negedge clk); rst_n = 1; @(posedge clk); #1;

        // R11 reset state
        check("R11 pend", 64'(pend_o), 64'h0);
        check("R11 en", 64'(en_o), 64'h0);
        rd_check("R11 mode word", 0, 32'h0);
        rd_check("R11 en bank", 136, 32'h0);

        // R1 mode codes and readback
        wr(0, 32'd1); cycle("R1 cfg1");
        rd_check("R1 read rising", 0, 32'd1);
        wr(1, 32'd6); cycle("R1 cfg code6");
        rd_check("R1 code6 reads 0", 1, 32'd0);
        wr(1, 32'd2); cycle("R1 cfg2");
        wr(2, 32'd3); cycle("R1 cfg3");
        wr(3, 32'd4); cycle("R1 cfg4");
        rd_check("R1 read low", 3, 32'd4);

        // R3 rising edge sticky
        irq[0] = 1; cycle("R3 rise");
        check("R3 set", 64'(pend_o[0]), 64'd1);
        irq[0] = 0; cycle("R3 hold");
        check("R3 sticky", 64'(pend_o[0]), 64'd1);

        // R4 falling edge
        irq[1] = 1; cycle("R4 high");
        check("R4 no set on rise", 64'(pend_o[1]), 64'd0);
        irq[1] = 0; cycle("R4 fall");
        check("R4 set", 64'(pend_o[1]), 64'd1);

        // R5 levels
        check("R5 low active", 64'(pend_o[3]), 64'd1);
        irq[2] = 1; irq[3] = 1; cycle("R5 lvl");
        check("R5 high follows", 64'(pend_o[2]), 64'd1);
        check("R5 low inverted", 64'(pend_o[3]), 64'd0);

        // R6 claim
        claim_valid = 1; claim_id = 8'd1; cycle("R6 claim edge");
        check("R6 edge cleared", 64'(pend_o[0]), 64'd0);
        claim_valid = 1; claim_id = 8'd3; cycle("R6 claim level");
        check("R6 level cleared", 64'(pend_o[2]), 64'd0);
        cycle("R6 level back");
        check("R6 level reasserts", 64'(pend_o[2]), 64'd1);
        irq[0] = 1; claim_valid = 1; claim_id = 8'd1; cycle("R6 claim with edge");
        check("R6 new edge wins", 64'(pend_o[0]), 64'd1);

        // R2 inactive
        wr(0, 32'd0); cycle("R2 off");
        check("R2 cleared by mode 0", 64'(pend_o[0]), 64'd0);
        irq[0] = 0; cycle("R2 t1"); irq[0] = 1; cycle("R2 t2");
        check("R2 quiet", 64'(pend_o[0]), 64'd0);

        // R10 history reset
        irq[4] = 1; cycle("R10 pre");
        wr(4, 32'd1); cycle("R10 cfg");
        cycle("R10 steady");
        check("R10 no edge", 64'(pend_o[4]), 64'd0);
        irq[5] = 1; wr(5, 32'd1); cycle("R10 edge with write");
        cycle("R10 after");
        check("R10 same-cycle edge dropped", 64'(pend_o[5]), 64'd0);

        // R7 enable by number
        wr(128, 32'd5); cycle("R7 set");
        check("R7 enabled", 64'(en_o[4]), 64'd1);
        wr(129, 32'd5); cycle("R7 clr");
        check("R7 disabled", 64'(en_o[4]), 64'd0);

        // R9 bad identities
        wr(128, 32'd0); cycle("R9 id0");
        wr(128, 32'd41); cycle("R9 id41");
        check("R9 en unchanged", 64'(en_o), 64'h0);
        claim_valid = 1; claim_id = 8'd41; cycle("R9 claim41");
        check("R9 claim ignored", 64'(pend_o[1]), 64'd1);

        // R8 banks
        for (int k = 1; k <= NSRC; k++) begin wr(128, 32'(k)); cycle("R8 fill"); end
        rd_check("R8 bank0 read", 136, 32'hFFFF_FFFE);
        rd_check("R8 bank1 read", 137, 32'h0000_01FF);
        wr(137, 32'hFFFF_FFFF); cycle("R8 bank clear");
        check("R8 upper off", 64'(en_o[39:31]), 64'h0);
        check("R8 lower kept", 64'(en_o[30:0]), 64'h7FFF_FFFF);
        rd_check("R8 pend bank0", 144, exp_read(144));

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            int op;
            if ($urandom_range(3) == 0) irq[$urandom_range(NSRC-1)] ^= 1'b1;
            op = $urandom_range(9);
            case (op)
                0: wr($urandom_range(NSRC+1), $urandom());
                1: wr(128, $urandom_range(NSRC+2));
                2: wr(129, $urandom_range(NSRC+2));
                3: wr(136 + $urandom_range(1), $urandom());
                default: ;
            endcase
            if ($urandom_range(2) == 0) begin
                claim_valid = 1; claim_id = ID_W'($urandom_range(NSRC+2));
            end
            cycle("R1-model random");
            if (n % 50 == 0) begin
                int a;
                a = (n % 100 == 0) ? $urandom_range(NSRC-1) : 136 + 8 * $urandom_range(1) + $urandom_range(1);
                rd_check("R8 random read", a, exp_read(a));
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule